// File: doc/BRIEF.md
# Accumulator-Style Fetch/Decode/Execute Sequencer

This block is the control core of a small 8-bit processor. It owns four general registers, a 4-bit program counter, an instruction register, a decoded-instruction register, a temporary result register and three condition flags. It walks each instruction through fetch, decode and execute, one step per clock. ALU instructions take an extra commit step in which the temporary result overwrites register 0. Instructions and data share one external 16-byte memory. The core drives its address, write data and write enable, and reads it back combinationally in the same cycle.

Every instruction is one byte. Bits 7:6 give the class, bits 5:4 give a register or control sub-group, and bits 3:0 give a memory address, a jump target, or a function/condition code in bits 1:0. Programs start at address 0 after reset and run until a halt instruction. The halt parks the core so that data bytes placed after the code are never fetched as instructions.

Top module: `toyacc_core`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_addr is 0, mem_we is 0 and halted is 0. Reset also clears all four registers, the three flags and the program counter, so a program that stores registers right after reset writes zeros.
- R2: Each instruction is fetched from the program counter. Bits 7:6 select the class: 00 ALU, 01 load, 10 store, 11 control. Every non-ALU instruction takes exactly 3 clocks and an ALU instruction takes exactly 4, so a program's run time from reset release to halted is the sum of these.
- R3: Load (01 rr aaaa) copies the memory byte at address aaaa into register rr, then advances the program counter by one.
- R4: Store (10 rr aaaa) raises mem_we for exactly one cycle with mem_addr = aaaa and mem_wdata = register rr, then advances the program counter by one.
- R5: An ALU instruction (00 rr xx ff) computes R0 op Rrr into a temporary register and writes it over R0 one cycle later. Function codes are ff: 00 add, 01 subtract (R0 - Rrr), 10 AND, 11 OR.
- R6: Flags are latched only when an ALU instruction commits. Z is set when the result is zero. N is set when result bit 7 is set. O is set on signed two's-complement overflow of add or subtract and is clear for AND and OR.
- R7: Unconditional jump (11 00 aaaa) loads aaaa into the program counter.
- R8: Conditional jump (11 01 xx cc) loads bits 3:0 of R3 into the program counter when its condition holds, otherwise advances by one. The conditions are cc: 00 O set, 01 Z set, 10 N set, 11 both Z and N clear.
- R9: Halt (11 10 xxxx) raises halted three clocks after its fetch begins. halted then stays high until reset, no write occurs, and mem_addr holds the halt instruction's address.
- R10: Control encoding 11 11 xxxx is a no-operation that only advances the program counter by one.
- R11: The program counter wraps from 15 to 0 when it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Byte read from memory at mem_addr in the same cycle |
| mem_addr | output | 4 | Memory address: program counter, or operand address during load/store execute |
| mem_wdata | output | 8 | Byte to be written when mem_we is high |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | High once a halt instruction has executed, until reset |

## Verification
The assertions assume memory answers combinationally: the byte at mem_addr is on mem_rdata within the same cycle, and a write lands at the clock edge that ends the store's execute step. They also assume reset is held for at least one edge before a program runs. The bench's memory model follows both rules. It loads each program image only while reset is high, so the contents never change under a running core except through its own stores. Random programs are screened by a bench instruction-level model, and only images that reach a halt within a bounded step count are run. Self-modifying stores stay legal because the model fetches from its own copy of memory.

// File: rtl/toyacc_pkg.sv
package toyacc_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int NREG   = 4;
    localparam int REG_W  = $clog2(NREG);
    localparam int CLS_W  = DATA_W - REG_W - ADDR_W;
    localparam int CODE_W = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [REG_W-1:0]  rsel_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU   = 2'b00,
        CLS_LOAD  = 2'b01,
        CLS_STORE = 2'b10,
        CLS_CTRL  = 2'b11
    } iclass_e;

    typedef enum logic [REG_W-1:0] {
        CTL_JUMP   = 2'b00,
        CTL_BRANCH = 2'b01,
        CTL_HALT   = 2'b10,
        CTL_NOP    = 2'b11
    } ctl_e;

    typedef enum logic [CODE_W-1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_AND = 2'b10,
        FN_OR  = 2'b11
    } alufn_e;

    typedef enum logic [CODE_W-1:0] {
        CND_OVF   = 2'b00,
        CND_ZERO  = 2'b01,
        CND_NEG   = 2'b10,
        CND_ABOVE = 2'b11
    } cond_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_COMMIT = 3'd3,
        ST_HALT   = 3'd4
    } state_e;

    typedef struct packed {
        logic ovf;
        logic zero;
        logic neg;
    } flags_t;

    typedef struct packed {
        iclass_e cls;
        rsel_t   rsel;
        addr_t   addr;
        ctl_e    ctl;
        alufn_e  fn;
        cond_e   cnd;
    } dec_t;

    typedef struct packed {
        word_t  value;
        flags_t flg;
    } alu_out_t;

    function automatic logic cond_met(cond_e c, flags_t f);
        logic hit;
        case (c)
            CND_OVF:   hit = f.ovf;
            CND_ZERO:  hit = f.zero;
            CND_NEG:   hit = f.neg;
            default:   hit = !f.zero && !f.neg;
        endcase
        return hit;
    endfunction

    function automatic addr_t pc_step(addr_t p);
        return p + addr_t'(1);
    endfunction

endpackage

// File: rtl/toyacc_decoder.sv
module toyacc_decoder
    import toyacc_pkg::*;
(
    input  word_t ir,
    output dec_t  dec
);
    localparam int CLS_LSB = REG_W + ADDR_W;

    always_comb begin
        dec.cls  = iclass_e'(ir[DATA_W-1:CLS_LSB]);
        dec.rsel = ir[CLS_LSB-1:ADDR_W];
        dec.addr = ir[ADDR_W-1:0];
        dec.ctl  = ctl_e'(ir[CLS_LSB-1:ADDR_W]);
        dec.fn   = alufn_e'(ir[CODE_W-1:0]);
        dec.cnd  = cond_e'(ir[CODE_W-1:0]);
    end
endmodule

// File: rtl/toyacc_alu.sv
module toyacc_alu
    import toyacc_pkg::*;
(
    input  word_t    a,
    input  word_t    b,
    input  alufn_e   fn,
    output alu_out_t res
);
    word_t sum_w;
    word_t dif_w;
    logic  sum_ov;
    logic  dif_ov;

    always_comb begin
        sum_w  = a + b;
        dif_w  = a - b;
        sum_ov = (a[DATA_W-1] == b[DATA_W-1]) && (sum_w[DATA_W-1] != a[DATA_W-1]);
        dif_ov = (a[DATA_W-1] != b[DATA_W-1]) && (dif_w[DATA_W-1] != a[DATA_W-1]);
        case (fn)
            FN_ADD: begin res.value = sum_w; res.flg.ovf = sum_ov; end
            FN_SUB: begin res.value = dif_w; res.flg.ovf = dif_ov; end
            FN_AND: begin res.value = a & b; res.flg.ovf = 1'b0;   end
            default: begin res.value = a | b; res.flg.ovf = 1'b0;  end
        endcase
        res.flg.zero = (res.value == '0);
        res.flg.neg  = res.value[DATA_W-1];
    end
endmodule

// File: rtl/toyacc_regfile.sv
module toyacc_regfile
    import toyacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  rsel_t wsel,
    input  word_t wdata,
    input  rsel_t rsel,
    output word_t rdata,
    output word_t acc,
    output addr_t target
);
    word_t regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (we && (wsel == rsel_t'(i))) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata  = regs[rsel];
    assign acc    = regs[0];
    assign target = regs[NREG-1][ADDR_W-1:0];
endmodule

// File: rtl/toyacc_core.sv
module toyacc_core
    import toyacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              halted
);
    state_e   state_q;
    addr_t    pc_q;
    word_t    ir_q;
    dec_t     dec_q;
    dec_t     dec_w;
    alu_out_t tmp_q;
    alu_out_t alu_w;
    flags_t   flags_q;

    logic  rf_we;
    rsel_t rf_wsel;
    word_t rf_wdata;
    word_t rf_rdata;
    word_t rf_acc;
    addr_t rf_target;

    logic  in_exec;
    logic  is_mem_op;

    toyacc_decoder u_dec (
        .ir  (ir_q),
        .dec (dec_w)
    );

    toyacc_alu u_alu (
        .a   (rf_acc),
        .b   (rf_rdata),
        .fn  (dec_q.fn),
        .res (alu_w)
    );

    toyacc_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .wsel   (rf_wsel),
        .wdata  (rf_wdata),
        .rsel   (dec_q.rsel),
        .rdata  (rf_rdata),
        .acc    (rf_acc),
        .target (rf_target)
    );

    assign in_exec   = (state_q == ST_EXEC);
    assign is_mem_op = (dec_q.cls == CLS_LOAD) || (dec_q.cls == CLS_STORE);

    always_comb begin
        mem_addr  = (in_exec && is_mem_op) ? dec_q.addr : pc_q;
        mem_we    = in_exec && (dec_q.cls == CLS_STORE);
        mem_wdata = rf_rdata;
        halted    = (state_q == ST_HALT);
    end

    always_comb begin
        rf_we    = 1'b0;
        rf_wsel  = dec_q.rsel;
        rf_wdata = mem_rdata;
        if (in_exec && (dec_q.cls == CLS_LOAD)) begin
            rf_we = 1'b1;
        end else if (state_q == ST_COMMIT) begin
            rf_we    = 1'b1;
            rf_wsel  = '0;
            rf_wdata = tmp_q.value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            dec_q   <= '0;
            tmp_q   <= '0;
            flags_q <= '0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    ir_q    <= mem_rdata;
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    dec_q   <= dec_w;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    state_q <= ST_FETCH;
                    case (dec_q.cls)
                        CLS_ALU: begin
                            tmp_q   <= alu_w;
                            state_q <= ST_COMMIT;
                        end
                        CLS_LOAD, CLS_STORE: pc_q <= pc_step(pc_q);
                        default: begin
                            case (dec_q.ctl)
                                CTL_JUMP:   pc_q <= dec_q.addr;
                                CTL_BRANCH: pc_q <= cond_met(dec_q.cnd, flags_q)
                                                    ? rf_target : pc_step(pc_q);
                                CTL_HALT:   state_q <= ST_HALT;
                                default:    pc_q <= pc_step(pc_q);
                            endcase
                        end
                    endcase
                end
                ST_COMMIT: begin
                    flags_q <= tmp_q.flg;
                    pc_q    <= pc_step(pc_q);
                    state_q <= ST_FETCH;
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end
endmodule

// File: rtl/toyacc_checker.sv
module toyacc_checker
    import toyacc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              halted,
    input state_e            state,
    input flags_t            flags
);
    AST_RESET_START: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == '0 && !mem_we && !halted)); // R1
    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_DECODE && $stable(mem_addr))); // R2
    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R4
    AST_COMMIT_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COMMIT) |=> (state == ST_FETCH)); // R5
    AST_FLAGS_ONLY_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (state != ST_COMMIT) |=> $stable(flags)); // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R9
    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we); // R9
    AST_HALT_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(mem_addr)); // R9
endmodule

bind toyacc_core toyacc_checker u_toyacc_checker (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .halted   (halted),
    .state    (state_q),
    .flags    (flags_q)
);

// File: tb/test_toyacc_core.sv
module test_toyacc_core;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_STEPS  = 60;
    localparam int MAX_CYC    = 400;
    localparam int N_RANDOM   = 30;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] mem_rdata;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic       halted;

    logic [7:0] prog_img [16];
    logic [7:0] tb_mem   [16];
    logic [7:0] mm       [16];

    int checks = 0;
    int errors = 0;
    bit watchdog_hit = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    toyacc_core i_toyacc_core (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .halted    (halted)
    );

    assign mem_rdata = tb_mem[mem_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) tb_mem[i] <= prog_img[i];
        end else if (mem_we) begin
            tb_mem[mem_addr] <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected ALU result per R5/R6: {ovf, zero, neg, value}
    function automatic logic [10:0] ref_alu(input logic [7:0] a, input logic [7:0] b,
                                            input logic [1:0] fn);
        logic [7:0] v;
        logic o;
        case (fn)
            2'd0: begin v = a + b; o = (a[7] == b[7]) && (v[7] != a[7]); end
            2'd1: begin v = a - b; o = (a[7] != b[7]) && (v[7] != a[7]); end
            2'd2: begin v = a & b; o = 1'b0; end
            default: begin v = a | b; o = 1'b0; end
        endcase
        return {o, (v == 8'd0), v[7], v};
    endfunction

    // Instruction-level model over mm[] giving cycles (R2), halt pc and final memory.
    task automatic model_run(output int cyc, output logic [3:0] hpc, output bit done);
        logic [7:0] r [4];
        logic [3:0] pc;
        logic fo, fz, fn;
        logic [7:0] ir;
        logic [10:0] ar;
        bit c;
        for (int i = 0; i < 4; i++) r[i] = 8'd0;
        pc = 4'd0; fo = 0; fz = 0; fn = 0; cyc = 0; done = 0; hpc = 4'd0;
        for (int s = 0; s < MAX_STEPS && !done; s++) begin
            ir = mm[pc];
            cyc += 3;
            case (ir[7:6])
                2'b00: begin
                    ar = ref_alu(r[0], r[ir[5:4]], ir[1:0]);
                    r[0] = ar[7:0]; fo = ar[10]; fz = ar[9]; fn = ar[8];
                    cyc += 1; pc = pc + 4'd1;
                end
                2'b01: begin r[ir[5:4]] = mm[ir[3:0]]; pc = pc + 4'd1; end
                2'b10: begin mm[ir[3:0]] = r[ir[5:4]]; pc = pc + 4'd1; end
                default: begin
                    case (ir[5:4])
                        2'b00: pc = ir[3:0];
                        2'b01: begin
                            case (ir[1:0])
                                2'd0: c = fo;
                                2'd1: c = fz;
                                2'd2: c = fn;
                                default: c = !fz && !fn;
                            endcase
                            pc = c ? r[3][3:0] : pc + 4'd1;
                        end
                        2'b10: begin done = 1; hpc = pc; end
                        default: pc = pc + 4'd1;
                    endcase
                end
            endcase
        end
    endtask

    task automatic run_prog(input string req);
        int exp_cyc, n, bad;
        logic [3:0] exp_pc;
        bit done;
        for (int i = 0; i < 16; i++) mm[i] = prog_img[i];
        model_run(exp_cyc, exp_pc, done);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(mem_addr == 4'd0 && !mem_we && !halted, "R1", "reset outputs",
              {mem_addr, 3'b0, mem_we, 3'b0, halted}, 0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (!halted && n < MAX_CYC) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        check(n == exp_cyc, "R2", {req, " cycles to halt"}, n, exp_cyc);
        check(mem_addr == exp_pc, "R9", {req, " halt address"}, mem_addr, exp_pc);
        repeat (3) @(negedge clk);
        check(halted && mem_addr == exp_pc && !mem_we, "R9", {req, " halt held"},
              {halted, mem_addr}, {1'b1, exp_pc});
        bad = -1;
        for (int i = 0; i < 16; i++) if (bad < 0 && tb_mem[i] !== mm[i]) bad = i;
        check(bad < 0, req, "final memory image",
              (bad < 0) ? 0 : {bad[7:0], tb_mem[bad[3:0]]},
              (bad < 0) ? 0 : {bad[7:0], mm[bad[3:0]]});
    endtask

    task automatic clear_img(input logic [7:0] fill);
        for (int i = 0; i < 16; i++) prog_img[i] = fill;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        watchdog_hit = 1;
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int tries, accepted, ec;
        logic [3:0] ep;
        bit dn;
        void'($urandom(32'd20240611));
        clear_img(8'hE0);
        rst = 1'b1;
        repeat (2) @(posedge clk);

        // R3 R5: load, add, store; 0x14 + 0x16 = 0x2A
        clear_img(8'hE0);
        prog_img[0] = 8'h4E; prog_img[1] = 8'h5F; prog_img[2] = 8'h10;
        prog_img[3] = 8'h8D; prog_img[4] = 8'hE0;
        prog_img[13] = 8'h00; prog_img[14] = 8'h14; prog_img[15] = 8'h16;
        run_prog("R3");
        check(tb_mem[13] == 8'h2A, "R5", "add result stored", tb_mem[13], 8'h2A);

        // R1: registers cleared by reset; prior program left R0/R1 nonzero
        clear_img(8'hFF);
        prog_img[0] = 8'h8C; prog_img[1] = 8'h9D; prog_img[2] = 8'hAE;
        prog_img[3] = 8'hBF; prog_img[4] = 8'hE0;
        run_prog("R1");
        check({tb_mem[12], tb_mem[13], tb_mem[14], tb_mem[15]} == 32'h0,
              "R1", "registers zero after reset",
              {tb_mem[12], tb_mem[13], tb_mem[14], tb_mem[15]}, 0);

        // R4 R6 R8: 0x7F + 0x01 overflows, branch-on-overflow taken to 7
        clear_img(8'hE0);
        prog_img[0] = 8'h4E; prog_img[1] = 8'h5F; prog_img[2] = 8'h7D;
        prog_img[3] = 8'h10; prog_img[4] = 8'hD0; prog_img[5] = 8'h8C;
        prog_img[7] = 8'h9C; prog_img[12] = 8'hAA;
        prog_img[13] = 8'h07; prog_img[14] = 8'h7F; prog_img[15] = 8'h01;
        run_prog("R4");
        check(tb_mem[12] == 8'h01, "R6", "overflow branch taken", tb_mem[12], 8'h01);

        // R8: 5 - 5 = 0; above not taken, zero taken to 8
        clear_img(8'hE0);
        prog_img[0] = 8'h4E; prog_img[1] = 8'h5F; prog_img[2] = 8'h7D;
        prog_img[3] = 8'h11; prog_img[4] = 8'hD3; prog_img[5] = 8'hD1;
        prog_img[8] = 8'h8C; prog_img[12] = 8'hAA;
        prog_img[13] = 8'h08; prog_img[14] = 8'h05; prog_img[15] = 8'h05;
        run_prog("R8");
        check(tb_mem[12] == 8'h00, "R8", "zero branch taken, above not", tb_mem[12], 8'h00);

        // R6 R8: OR gives 0x81 (N set), branch on negative, then AND gives 0x01
        clear_img(8'hE0);
        prog_img[0] = 8'h4E; prog_img[1] = 8'h5F; prog_img[2] = 8'h7D;
        prog_img[3] = 8'h13; prog_img[4] = 8'hD2; prog_img[8] = 8'h12;
        prog_img[9] = 8'h8C; prog_img[12] = 8'hAA;
        prog_img[13] = 8'h08; prog_img[14] = 8'h80; prog_img[15] = 8'h01;
        run_prog("R6");
        check(tb_mem[12] == 8'h01, "R8", "negative branch then AND", tb_mem[12], 8'h01);

        // R7 R10 R11: self-modify address 0 into halt, jump to 15, no-op wraps to 0
        clear_img(8'h00);
        prog_img[0] = 8'h5D; prog_img[1] = 8'h90; prog_img[2] = 8'hCF;
        prog_img[13] = 8'hE0; prog_img[15] = 8'hF0;
        run_prog("R7");
        check(mem_addr == 4'd0 && halted, "R11", "wrap to address 0 after no-op (R10)",
              mem_addr, 0);

        // Random programs screened by the model
        accepted = 0;
        tries = 0;
        while (accepted < N_RANDOM && tries < 5000) begin
            tries++;
            for (int i = 0; i < 16; i++) prog_img[i] = 8'($urandom);
            for (int i = 0; i < 16; i++) mm[i] = prog_img[i];
            model_run(ec, ep, dn);
            if (dn) begin
                accepted++;
                run_prog("R2");
            end
        end
        check(accepted == N_RANDOM, "R2", "random programs accepted", accepted, N_RANDOM);

        if (!watchdog_hit) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule